// File: doc/BRIEF.md
# Two-Stage Complex Correlation Integrator

This block integrates complex correlation results on up to eight lanes in parallel. On every accepted input packet, each enabled lane adds a signed complex sample (13-bit I and Q) into a 16-bit complex coherent sum. The sum restarts after a programmed number of packets. All lanes share one period counter, so every lane finishes its coherent period on the same cycle.

The second stage can be switched on or off at run time. When it is off, each finished coherent sum goes straight to the output. The sum is sent either at full width or reduced to 8-bit I and Q parts. When it is on, each finished coherent sum becomes an unsigned 16-bit amplitude. These amplitudes are summed over a programmed number of coherent periods, and only the final total is sent. Every output word carries a kind flag and its lane index, so that a downstream queue can sort the results.

Top module: `coh_ncoh_integrator`

## Requirements
- R1: While reset is asserted, and after it is released until the first dump, `out_valid` is 0 and `out_lane_vld` is all zeros.
- R2: A coherent period is `coh_len` accepted packets long, and a value of 0 acts as 1. Each enabled lane's sum is the signed total of that period's I and Q inputs. The first packet of a period starts the sum afresh.
- R3: Coherent sums saturate at +32767 and -32768 instead of wrapping.
- R4: With `ncoh_en`=0, each finished coherent sum appears with `out_valid`=1 in the second clock cycle after the edge that accepted the period's last packet. The payload is Q in bits [31:16] and I in bits [15:0].
- R5: With `reduce_en`=1, the coherent payload holds the reduced I in bits [7:0] and the reduced Q in bits [15:8], with bits [31:16] zero. Each reduced part equals (x+128)>>>8, clamped to the range -128..127.
- R6: With `ncoh_en`=1, each finished coherent sum is converted to the amplitude max(|I|,|Q|) + floor(min(|I|,|Q|)/2), saturated at 65535.
- R7: With `ncoh_en`=1, amplitudes are summed over `ncoh_len` coherent periods (0 acts as 1), saturating at 65535. The sum is output only in the third cycle after the last packet of the final period, with the payload in bits [15:0] and bits [31:16] zero. No word is output after the earlier periods.
- R8: Each lane's output word is {kind, lane index, payload}. The most significant bit is 1 for a non-coherent result and 0 for a coherent one. The lane index occupies the next log2(LANES) bits.
- R9: On a dump, `out_lane_vld` equals `lane_en`. A disabled lane's input has no effect on the enabled lanes, and a disabled lane restarts from zero.
- R10: Cycles with `in_valid`=0 are ignored. They neither advance a period nor change a sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet present this cycle |
| lane_en | input | LANES | Lane enable mask |
| in_i | input | LANES*IN_W | Signed I sample per lane, lane 0 in the low bits |
| in_q | input | LANES*IN_W | Signed Q sample per lane, lane 0 in the low bits |
| coh_len | input | LEN_W | Packets per coherent period (0 acts as 1) |
| ncoh_len | input | NCNT_W | Coherent periods per non-coherent dump (0 acts as 1) |
| ncoh_en | input | 1 | Enables the amplitude and non-coherent stage |
| reduce_en | input | 1 | Sends coherent results as 8-bit parts |
| out_valid | output | 1 | Dump pulse |
| out_lane_vld | output | LANES | Lanes whose word is valid in this dump |
| out_data | output | LANES*WORD_W | Tagged result words, lane 0 in the low bits |

## Verification
The bench builds the block with four lanes, a 4-bit coherent length and a 3-bit non-coherent count. This makes every coherent length from 0 to 15 and every non-coherent count from 0 to 7 cheap to sweep. Fifteen full-scale 13-bit samples drive the 16-bit sums past both saturation limits. Two or three full-scale amplitudes exceed 65535. Hand-picked sums sit on the rounding edges of the 8-bit reduction. The lane masks, the idle gaps between packets and the dump timing are checked in all of these sweeps.

// File: rtl/ccnc_pkg.sv
package ccnc_pkg;

  // Kind flag carried in the top bit of every result word
  localparam logic FLAG_COH  = 1'b0;
  localparam logic FLAG_NCOH = 1'b1;

  // Timing strobes shared by all lanes
  typedef struct packed {
    logic coh_first;  // current packet opens a coherent period
    logic coh_done;   // coherent sums finished at the last edge
    logic nc_first;   // finished coherent period opens a non-coherent span
    logic nc_done;    // non-coherent sums finished at the last edge
  } seq_ctl_t;

endpackage

// File: rtl/ccnc_seq.sv
module ccnc_seq
  import ccnc_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int NCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              ncoh_en,
  input  logic [LEN_W-1:0]  coh_len,
  input  logic [NCNT_W-1:0] ncoh_len,
  output seq_ctl_t          ctl
);

  logic [LEN_W-1:0]  sc_q, sc_d, coh_lim;
  logic [NCNT_W-1:0] pc_q, pc_d, nc_lim;
  logic              coh_last, nc_last;
  logic              coh_done_q, coh_done_d;
  logic              nc_done_q, nc_done_d;

  always_comb begin
    coh_lim  = (coh_len == '0)  ? '0 : coh_len - LEN_W'(1);
    nc_lim   = (ncoh_len == '0) ? '0 : ncoh_len - NCNT_W'(1);
    coh_last = (sc_q == coh_lim);
    nc_last  = (pc_q == nc_lim);

    sc_d = sc_q;
    if (in_valid) sc_d = coh_last ? '0 : sc_q + LEN_W'(1);
    coh_done_d = in_valid & coh_last;

    pc_d = pc_q;
    if (coh_done_q & ncoh_en) pc_d = nc_last ? '0 : pc_q + NCNT_W'(1);
    nc_done_d = coh_done_q & ncoh_en & nc_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q       <= '0;
      pc_q       <= '0;
      coh_done_q <= 1'b0;
      nc_done_q  <= 1'b0;
    end else begin
      sc_q       <= sc_d;
      pc_q       <= pc_d;
      coh_done_q <= coh_done_d;
      nc_done_q  <= nc_done_d;
    end
  end

  assign ctl.coh_first = (sc_q == '0);
  assign ctl.coh_done  = coh_done_q;
  assign ctl.nc_first  = (pc_q == '0);
  assign ctl.nc_done   = nc_done_q;

  // R2
  coh_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coh_done_q |-> $past(in_valid));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sc_q));

  // R7
  nc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nc_done_q |-> ($past(coh_done_q) && $past(ncoh_en)));

endmodule

// File: rtl/ccnc_coh_lane.sv
module ccnc_coh_lane #(
  parameter int IN_W  = 13,
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    first,
  input  logic                    lane_en,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  output logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] acc_q
);

  localparam int XW = ACC_W + 1;
  localparam logic signed [XW-1:0] SMAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [XW-1:0] SMIN = ~SMAX;

  logic signed [ACC_W-1:0] acc_i_q, acc_q_q, acc_i_d, acc_q_d;
  logic signed [XW-1:0]    base_i, base_q, sum_i, sum_q;

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > SMAX)      return SMAX[ACC_W-1:0];
    else if (v < SMIN) return SMIN[ACC_W-1:0];
    else               return v[ACC_W-1:0];
  endfunction

  always_comb begin
    base_i = first ? '0 : $signed({acc_i_q[ACC_W-1], acc_i_q});
    base_q = first ? '0 : $signed({acc_q_q[ACC_W-1], acc_q_q});
    sum_i  = base_i + $signed({{(XW-IN_W){in_i[IN_W-1]}}, in_i});
    sum_q  = base_q + $signed({{(XW-IN_W){in_q[IN_W-1]}}, in_q});
    acc_i_d = acc_i_q;
    acc_q_d = acc_q_q;
    if (in_valid) begin
      acc_i_d = lane_en ? clamp(sum_i) : '0;
      acc_q_d = lane_en ? clamp(sum_q) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i_q <= '0;
      acc_q_q <= '0;
    end else begin
      acc_i_q <= acc_i_d;
      acc_q_q <= acc_q_d;
    end
  end

  assign acc_i = acc_i_q;
  assign acc_q = acc_q_q;

  // R3
  coh_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !first && lane_en && !in_i[IN_W-1]) |=> (acc_i_q >= $past(acc_i_q)));

endmodule

// File: rtl/ccnc_amp.sv
module ccnc_amp #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] ci,
  input  logic signed [W-1:0] cq,
  output logic        [W-1:0] amp
);

  logic [W-1:0] ai, aq, mx, mn;
  logic [W:0]   sum;

  always_comb begin
    ai  = ci[W-1] ? (~ci + W'(1)) : ci;
    aq  = cq[W-1] ? (~cq + W'(1)) : cq;
    mx  = (ai >= aq) ? ai : aq;
    mn  = (ai >= aq) ? aq : ai;
    sum = {1'b0, mx} + {2'b00, mn[W-1:1]};
    amp = sum[W] ? {W{1'b1}} : sum[W-1:0];
    // R6
    amp_floor_chk: assert (amp >= ai && amp >= aq);
  end

endmodule

// File: rtl/ccnc_ncoh_lane.sv
module ccnc_ncoh_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         first,
  input  logic         lane_en,
  input  logic [W-1:0] amp,
  output logic [W-1:0] nacc
);

  logic [W-1:0] nacc_q, nacc_d;
  logic [W:0]   sum;

  always_comb begin
    sum    = (first ? {(W+1){1'b0}} : {1'b0, nacc_q}) + {1'b0, amp};
    nacc_d = nacc_q;
    if (step) nacc_d = !lane_en ? '0 : (sum[W] ? {W{1'b1}} : sum[W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nacc_q <= '0;
    else        nacc_q <= nacc_d;
  end

  assign nacc = nacc_q;

  // R7
  nc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !first && lane_en) |=> (nacc_q >= $past(nacc_q)));

endmodule

// File: rtl/coh_ncoh_integrator.sv
module coh_ncoh_integrator
  import ccnc_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int IN_W   = 13,
  parameter int ACC_W  = 16,
  parameter int RED_W  = 8,
  parameter int LEN_W  = 8,
  parameter int NCNT_W = 8,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int PAY_W  = 2 * ACC_W,
  localparam int WORD_W = 1 + LIDX_W + PAY_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*IN_W-1:0]   in_i,
  input  logic [LANES*IN_W-1:0]   in_q,
  input  logic [LEN_W-1:0]        coh_len,
  input  logic [NCNT_W-1:0]       ncoh_len,
  input  logic                    ncoh_en,
  input  logic                    reduce_en,
  output logic                    out_valid,
  output logic [LANES-1:0]        out_lane_vld,
  output logic [LANES*WORD_W-1:0] out_data
);

  localparam int SH = ACC_W - RED_W;
  localparam logic [ACC_W-1:0] RND = ACC_W'(1) << (SH - 1);
  localparam logic signed [ACC_W:0] RMAX = (ACC_W+1)'((1 << (RED_W - 1)) - 1);
  localparam logic signed [ACC_W:0] RMIN = ~RMAX;

  function automatic logic [RED_W-1:0] reduce(input logic signed [ACC_W-1:0] x);
    logic signed [ACC_W:0] t;
    t = ($signed({x[ACC_W-1], x}) + $signed({1'b0, RND})) >>> SH;
    if (t > RMAX)      return RMAX[RED_W-1:0];
    else if (t < RMIN) return RMIN[RED_W-1:0];
    else               return t[RED_W-1:0];
  endfunction

  seq_ctl_t ctl;
  logic     ld_coh, ld_nc, ld;
  logic     valid_q, valid_d;
  logic [LANES-1:0] mask_q, mask_d;

  ccnc_seq #(.LEN_W(LEN_W), .NCNT_W(NCNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .ncoh_en  (ncoh_en),
    .coh_len  (coh_len),
    .ncoh_len (ncoh_len),
    .ctl      (ctl)
  );

  always_comb begin
    ld_coh  = ctl.coh_done & ~ncoh_en;
    ld_nc   = ctl.nc_done;
    ld      = ld_coh | ld_nc;
    valid_d = ld;
    mask_d  = ld ? lane_en : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACC_W-1:0] acc_i, acc_q;
    logic [ACC_W-1:0]        amp, nacc;
    logic [WORD_W-1:0]       word_q, word_d;
    logic [PAY_W-1:0]        coh_pay;

    ccnc_coh_lane #(.IN_W(IN_W), .ACC_W(ACC_W)) u_coh (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .first    (ctl.coh_first),
      .lane_en  (lane_en[l]),
      .in_i     (in_i[l*IN_W +: IN_W]),
      .in_q     (in_q[l*IN_W +: IN_W]),
      .acc_i    (acc_i),
      .acc_q    (acc_q)
    );

    ccnc_amp #(.W(ACC_W)) u_amp (
      .ci  (acc_i),
      .cq  (acc_q),
      .amp (amp)
    );

    ccnc_ncoh_lane #(.W(ACC_W)) u_ncoh (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (ctl.coh_done & ncoh_en),
      .first   (ctl.nc_first),
      .lane_en (lane_en[l]),
      .amp     (amp),
      .nacc    (nacc)
    );

    always_comb begin
      coh_pay = reduce_en ? {{(PAY_W-2*RED_W){1'b0}}, reduce(acc_q), reduce(acc_i)}
                          : {acc_q, acc_i};
      word_d = word_q;
      if (ld_nc)       word_d = {FLAG_NCOH, LIDX_W'(l), {ACC_W{1'b0}}, nacc};
      else if (ld_coh) word_d = {FLAG_COH, LIDX_W'(l), coh_pay};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign out_data[l*WORD_W +: WORD_W] = word_q;
  end

  assign out_valid    = valid_q;
  assign out_lane_vld = mask_q;

  // R9
  mask_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_q) |-> valid_q);

  // R4
  coh_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.coh_done && !ncoh_en) |=> valid_q);

  // R7
  nc_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.nc_done |=> (valid_q && out_data[WORD_W-1]));

endmodule

// File: tb/coh_ncoh_integrator_bench.sv
`timescale 1ns/1ps
module coh_ncoh_integrator_bench;
  localparam int LANES = 4, IN_W = 13, ACC_W = 16, RED_W = 8, LEN_W = 4, NCNT_W = 3;
  localparam int LIDX_W = 2, WORD_W = 1 + LIDX_W + 2 * ACC_W;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [LANES-1:0] lane_en;
  logic [LANES*IN_W-1:0] in_i, in_q;
  logic [LEN_W-1:0] coh_len;
  logic [NCNT_W-1:0] ncoh_len;
  logic ncoh_en, reduce_en;
  logic out_valid;
  logic [LANES-1:0] out_lane_vld;
  logic [LANES*WORD_W-1:0] out_data;

  always #2.5 clk = ~clk;

  coh_ncoh_integrator #(.LANES(LANES), .IN_W(IN_W), .ACC_W(ACC_W), .RED_W(RED_W),
                        .LEN_W(LEN_W), .NCNT_W(NCNT_W)) u_coh_ncoh_integrator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_en(lane_en),
    .in_i(in_i), .in_q(in_q), .coh_len(coh_len), .ncoh_len(ncoh_len),
    .ncoh_en(ncoh_en), .reduce_en(reduce_en), .out_valid(out_valid),
    .out_lane_vld(out_lane_vld), .out_data(out_data));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;
  int pi[LANES], pq[LANES], fi[LANES], fq[LANES];
  int mi[LANES], mq[LANES], mn[LANES];
  int pkt_idx, per_idx;
  bit fixed_mode;

  function automatic int rnd13();
    int v;
    seed = seed * 32'd1103515245 + 32'd12345;
    v = int'((seed >> 12) & 32'h1FFF);
    if (v >= 4096) v -= 8192;
    return v;
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int ampf(int i, int q);
    int ai, aq, mx, mnv, s;
    ai = (i < 0) ? -i : i;
    aq = (q < 0) ? -q : q;
    mx = (ai > aq) ? ai : aq;
    mnv = (ai > aq) ? aq : ai;
    s = mx + mnv / 2;
    return (s > 65535) ? 65535 : s;
  endfunction

  function automatic int red8(int x);
    int t;
    t = (x + 128) >>> 8;
    if (t > 127) return 127;
    if (t < -128) return -128;
    return t;
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid in reset", 64'(out_valid), 64'd0);
    check("R1 mask in reset", 64'(out_lane_vld), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(out_valid), 64'd0);
    for (int l = 0; l < LANES; l++) begin mi[l] = 0; mq[l] = 0; mn[l] = 0; end
  endtask

  task automatic push();
    for (int l = 0; l < LANES; l++) begin
      if (fixed_mode) begin pi[l] = fi[l]; pq[l] = fq[l]; end
      else begin pi[l] = rnd13(); pq[l] = rnd13(); end
      in_i[l*IN_W +: IN_W] = IN_W'(pi[l]);
      in_q[l*IN_W +: IN_W] = IN_W'(pq[l]);
      if (!lane_en[l]) begin mi[l] = 0; mq[l] = 0; end
      else if (pkt_idx == 0) begin mi[l] = pi[l]; mq[l] = pq[l]; end
      else begin mi[l] = sat16(mi[l] + pi[l]); mq[l] = sat16(mq[l] + pq[l]); end
    end
    in_valid = 1'b1;
    pkt_idx++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_period(int n, bit gap);
    pkt_idx = 0;
    for (int k = 0; k < n; k++) begin
      push();
      if (gap && k < n - 1) begin
        in_i = '1; in_q = '1;  // junk on idle cycles, R10
        @(negedge clk);
      end
    end
  endtask

  // coherent dump: checked two cycles after the last packet edge
  task automatic coh_check(int n, bit gap, string req);
    logic [WORD_W-1:0] e;
    send_period(n, gap);
    check({req, " R4 no early valid"}, 64'(out_valid), 64'd0);
    @(negedge clk);
    check({req, " R4 valid"}, 64'(out_valid), 64'd1);
    check({req, " R9 mask"}, 64'(out_lane_vld), 64'(lane_en));
    for (int l = 0; l < LANES; l++) if (lane_en[l]) begin
      if (reduce_en) e = {1'b0, LIDX_W'(l), 16'h0, 8'(red8(mq[l])), 8'(red8(mi[l]))};
      else           e = {1'b0, LIDX_W'(l), 16'(mq[l]), 16'(mi[l])};
      check({req, " R8 coherent word"}, 64'(out_data[l*WORD_W +: WORD_W]), 64'(e));
    end
  endtask

  task automatic nc_check(int n, int periods, string req);
    logic [WORD_W-1:0] e;
    per_idx = 0;
    for (int p = 0; p < periods; p++) begin
      send_period(n, 1'b0);
      for (int l = 0; l < LANES; l++) begin
        if (!lane_en[l]) mn[l] = 0;
        else if (per_idx == 0) mn[l] = ampf(mi[l], mq[l]);
        else begin
          mn[l] = mn[l] + ampf(mi[l], mq[l]);
          if (mn[l] > 65535) mn[l] = 65535;
        end
      end
      per_idx++;
      @(negedge clk);
      @(negedge clk);
      if (p < periods - 1) check({req, " R7 no early dump"}, 64'(out_valid), 64'd0);
      else begin
        check({req, " R7 dump valid"}, 64'(out_valid), 64'd1);
        check({req, " R9 mask"}, 64'(out_lane_vld), 64'(lane_en));
        for (int l = 0; l < LANES; l++) if (lane_en[l]) begin
          e = {1'b1, LIDX_W'(l), 16'h0, 16'(mn[l])};
          check({req, " R6 R8 non-coherent word"}, 64'(out_data[l*WORD_W +: WORD_W]), 64'(e));
        end
      end
    end
  endtask

  initial begin
    in_i = '0; in_q = '0; lane_en = '1; coh_len = '0; ncoh_len = '0;
    ncoh_en = 1'b0; reduce_en = 1'b0; fixed_mode = 1'b0;
    do_reset();

    // R2 R4 R10: every coherent length, with and without idle gaps
    for (int cl = 0; cl < 16; cl++) begin
      coh_len = LEN_W'(cl);
      coh_check((cl == 0) ? 1 : cl, cl[0], "R2");
      coh_check((cl == 0) ? 1 : cl, 1'b0, "R2");
    end

    // R5 rounding edges
    reduce_en = 1'b1; coh_len = 1; fixed_mode = 1'b1;
    fi = '{127, 128, -128, -129}; fq = '{-129, -128, 128, 127};
    coh_check(1, 1'b0, "R5 round");
    fixed_mode = 1'b0; coh_len = 5;
    coh_check(5, 1'b1, "R5 random");
    // R3 R5 saturated then reduced
    fixed_mode = 1'b1; coh_len = 9;
    fi = '{4095, -4096, 4095, -4096}; fq = '{-4096, 4095, 0, 1};
    coh_check(9, 1'b0, "R5 sat");
    // R3 full-width saturation
    reduce_en = 1'b0; coh_len = 15;
    coh_check(15, 1'b0, "R3");

    // R9 lane masks
    fixed_mode = 1'b0;
    lane_en = 4'b0101; coh_len = 3; coh_check(3, 1'b0, "R9");
    lane_en = 4'b1010; coh_len = 2; coh_check(2, 1'b1, "R9");
    lane_en = 4'b0000; coh_len = 1; coh_check(1, 1'b0, "R9 none");
    lane_en = 4'b1111; coh_check(1, 1'b0, "R9 restart");

    // R6 R7 non-coherent sweep
    ncoh_en = 1'b1;
    do_reset();
    for (int cl = 1; cl < 4; cl += 2) begin
      coh_len = LEN_W'(cl);
      for (int nl = 0; nl < 8; nl++) begin
        ncoh_len = NCNT_W'(nl);
        nc_check(cl, (nl == 0) ? 1 : nl, "R7");
        nc_check(cl, (nl == 0) ? 1 : nl, "R7 repeat");
      end
    end

    // R6 R7 amplitude extremes and saturation
    fixed_mode = 1'b1; coh_len = 15; ncoh_len = 3;
    fi = '{4095, -4096, 100, 0}; fq = '{-4096, -4096, -3, 0};
    nc_check(15, 3, "R6 sat");
    ncoh_len = 1; coh_len = 1;
    fi = '{-7, 3, 0, -4096}; fq = '{2, -9, 5, 4095};
    nc_check(1, 1, "R6 single");

    // R9 mask with the second stage on
    fixed_mode = 1'b0; lane_en = 4'b0110; coh_len = 2; ncoh_len = 2;
    nc_check(2, 2, "R9 nc");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule